// File: doc/BRIEF.md
# Two-Wire Register Target with Pointer Selection

This block is the bus-facing end of a small sensor: a target on a two-wire (I2C-style) serial bus that lets an external controller read a temperature word and read or write three settings words. It watches the clock and data lines through synchronizers in the system clock domain. It recognises START, repeated START and STOP, compares a 7-bit device address and keeps a pointer that chooses which register the next data bytes reach. The data line is open-drain: the block only ever pulls it low.

A write transaction sends the address with the direction bit at 0, then the pointer byte, then the data bytes for the selected register. A read transaction sends the address with the direction bit at 1 and returns the register the pointer already selects. The pointer survives from one transaction to the next, so repeated reads of the same register can skip it. To change the register and read it in one go, the controller writes the pointer, issues a repeated START and then reads. The byte count follows the register: the settings byte moves one byte, the three wide registers move two. A controller may stop a two-byte read after the high byte.

Top module: `tw_ptr_target`

## Requirements
- R1: A START or repeated START, seen in any state, begins a new address phase. A STOP returns the target to idle with SDA released.
- R2: When bits 7..1 of the first byte equal the parameter DEV_ADDR, the target acknowledges by pulling SDA low for the ninth clock. On a mismatch it does not acknowledge and leaves SDA released until the next START.
- R3: In a write, the byte after the address is the pointer. It is acknowledged, and its bits 1..0 select 00 temperature, 01 settings byte, 10 low threshold, 11 high threshold. The pointer is kept across transactions.
- R4: A write to the settings byte carries one data byte, which is acknowledged and stored. Any further byte in that transaction is not acknowledged and is ignored.
- R5: A write to either threshold takes two bytes, high byte first. The register changes only when the second byte arrives: a STOP after the first byte leaves it unchanged. A third byte is not acknowledged.
- R6: A write aimed at the temperature register has both data bytes acknowledged and has no effect.
- R7: A read with the direction bit at 1 returns the selected register MSb first. The first bit is on SDA after the acknowledge clock of the address ends. A read of the settings byte returns one byte.
- R8: A read of temperature or a threshold returns the high byte, then the low byte if the controller ACKs. If the controller NACKs the high byte, the target sends nothing more. Both bytes come from one sample taken when the address is acknowledged.
- R9: SDA is only ever pulled low or released, and the target changes it only while SCL is low.
- R10: After reset the settings byte is 0x00, the low threshold is HYST_RST (0x4B00), the high threshold is OVER_RST (0x5000), the pointer selects temperature and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| temp_in | input | 16 | Temperature word supplied by the sensor core |
| cfg_q | output | 8 | Settings byte |
| thyst_q | output | 16 | Low threshold word |
| tover_q | output | 16 | High threshold word |

## Verification
On every cycle the assertions check several properties. SDA moves only while the synchronized SCL is low. A STOP leaves the target idle and released. An idle target never pulls the line. At most one register write strobe fires at a time, a threshold commits only on its second byte, and a NACK on a read byte cancels any further transmission. The bench scenarios are the only place to show a number of other behaviours. These are the byte counts per register, the pointer surviving between transactions, a discarded temperature write, the NACK of surplus bytes, an address mismatch leaving the bus untouched, and both read bytes coming from one snapshot while temp_in changes.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    SEL_TEMP = 2'b00,
    SEL_CFG  = 2'b01,
    SEL_HYST = 2'b10,
    SEL_OVER = 2'b11
  } reg_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } bus_st_e;
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // STAGES flops synchronize; the extra top flop holds the previous level
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_n;

  always_comb chain_n = {chain_q[STAGES-1:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_n;
  end

  assign lvl  = chain_q[STAGES-1];
  assign rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/tw_regs.sv
module tw_regs import tw_pkg::*; #(
  parameter int          DW       = 16,
  parameter logic [15:0] HYST_RST = 16'h4B00,
  parameter logic [15:0] OVER_RST = 16'h5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_we,
  input  logic [1:0]    ptr_d,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_d,
  input  logic          thr_we,
  input  logic [DW-1:0] thr_d,
  input  logic [DW-1:0] temp_in,
  output reg_sel_e      ptr_q,
  output logic [7:0]    cfg_q,
  output logic [DW-1:0] thyst_q,
  output logic [DW-1:0] tover_q,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= SEL_TEMP;
      cfg_q   <= '0;
      thyst_q <= HYST_RST;
      tover_q <= OVER_RST;
    end else begin
      if (ptr_we) ptr_q <= reg_sel_e'(ptr_d);
      if (cfg_we) cfg_q <= cfg_d;
      if (thr_we && ptr_q == SEL_HYST) thyst_q <= thr_d;
      if (thr_we && ptr_q == SEL_OVER) tover_q <= thr_d;
    end
  end

  // Settings byte is returned left-aligned; only its high byte is ever sent
  always_comb begin
    unique case (ptr_q)
      SEL_TEMP: rd_data = temp_in;
      SEL_CFG:  rd_data = {cfg_q, {(DW-8){1'b0}}};
      SEL_HYST: rd_data = thyst_q;
      default:  rd_data = tover_q;
    endcase
  end

  // R10: the settings byte moves only one cycle after a write strobe
  a_r10_cfg_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(cfg_we));
endmodule

// File: rtl/tw_bus_fsm.sv
module tw_bus_fsm import tw_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_lvl,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        sda_lvl,
  input  logic        sda_rise,
  input  logic        sda_fall,
  input  reg_sel_e    ptr_q,
  input  logic [15:0] rd_data,
  output logic        ptr_we,
  output logic [1:0]  ptr_d,
  output logic        cfg_we,
  output logic [7:0]  cfg_d,
  output logic        thr_we,
  output logic [15:0] thr_d,
  output logic        sda_pull
);
  bus_st_e     st_q, st_n;
  logic [2:0]  cnt_q, cnt_n;
  logic [7:0]  sh_q, sh_n, msb_q, msb_n, lsb_q, lsb_n;
  logic [1:0]  idx_q, idx_n;
  logic        got_q, got_n, rw_q, rw_n, ackok_q, ackok_n, pull_q, pull_n;
  logic        start_ev, stop_ev, two_byte, accept;

  assign start_ev = sda_fall & scl_lvl;
  assign stop_ev  = sda_rise & scl_lvl;
  assign two_byte = (ptr_q != SEL_CFG);
  assign accept   = (idx_q == 2'd0) | (two_byte & (idx_q == 2'd1));

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; msb_n = msb_q; lsb_n = lsb_q;
    idx_n = idx_q; got_n = got_q; rw_n = rw_q; ackok_n = ackok_q; pull_n = pull_q;
    ptr_we = 1'b0; cfg_we = 1'b0; thr_we = 1'b0;
    if (start_ev) begin
      st_n = ST_ADDR; cnt_n = '0; got_n = 1'b0; pull_n = 1'b0;
    end else if (stop_ev) begin
      st_n = ST_IDLE; got_n = 1'b0; pull_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_lvl};
            cnt_n = cnt_q + 3'd1;
            if (cnt_q == 3'd7) got_n = 1'b1;
          end else if (scl_fall && got_q) begin
            got_n = 1'b0; cnt_n = '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                pull_n = 1'b1; rw_n = sh_q[0]; st_n = ST_AACK;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st_q == ST_PTR) begin
              ptr_we = 1'b1; pull_n = 1'b1; st_n = ST_PACK;
            end else if (accept) begin
              pull_n = 1'b1; st_n = ST_WACK; idx_n = idx_q + 2'd1;
              if (ptr_q == SEL_CFG)                      cfg_we = 1'b1;
              else if (ptr_q != SEL_TEMP && idx_q == 2'd0) msb_n = sh_q;
              else if (ptr_q != SEL_TEMP)                  thr_we = 1'b1;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          if (rw_q) begin
            st_n = ST_RDATA; sh_n = rd_data[15:8]; lsb_n = rd_data[7:0];
            pull_n = ~rd_data[15]; cnt_n = '0; idx_n = '0;
          end else begin
            st_n = ST_PTR; pull_n = 1'b0;
          end
        end
        ST_PACK: if (scl_fall) begin
          st_n = ST_WDATA; pull_n = 1'b0; idx_n = '0;
        end
        ST_WACK: if (scl_fall) begin
          st_n = ST_WDATA; pull_n = 1'b0;
        end
        ST_RDATA: if (scl_fall) begin
          if (cnt_q == 3'd7) begin
            pull_n = 1'b0; st_n = ST_RACK;
          end else begin
            sh_n = {sh_q[6:0], 1'b0}; pull_n = ~sh_q[6]; cnt_n = cnt_q + 3'd1;
          end
        end
        ST_RACK: begin
          if (scl_rise) ackok_n = ~sda_lvl & two_byte & (idx_q == 2'd0);
          else if (scl_fall) begin
            ackok_n = 1'b0;
            if (ackok_q) begin
              st_n = ST_RDATA; sh_n = lsb_q; pull_n = ~lsb_q[7];
              cnt_n = '0; idx_n = 2'd1;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; msb_q <= '0; lsb_q <= '0;
      idx_q <= '0; got_q <= 1'b0; rw_q <= 1'b0; ackok_q <= 1'b0; pull_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; msb_q <= msb_n; lsb_q <= lsb_n;
      idx_q <= idx_n; got_q <= got_n; rw_q <= rw_n; ackok_q <= ackok_n; pull_q <= pull_n;
    end
  end

  assign ptr_d    = sh_q[1:0];
  assign cfg_d    = sh_q;
  assign thr_d    = {msb_q, sh_q};
  assign sda_pull = pull_q;

  // R9: the data line only moves while the clock line is low
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_lvl);
  // R1: a STOP leaves the target idle and released
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st_q == ST_IDLE) && !pull_q);
  // R2: an idle (or unaddressed) target never pulls the line
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !pull_q);
  // R4: at most one register write per cycle
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ptr_we, cfg_we, thr_we}));
  // R5: a threshold commits only with its second byte
  a_r5_thr_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |-> (idx_q == 2'd1) && (st_q == ST_WDATA));
  // R8: a NACKed read byte is never followed by more data
  a_r8_nack_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RACK && scl_rise && sda_lvl) |=> !ackok_q);
endmodule

// File: rtl/tw_ptr_target.sv
module tw_ptr_target import tw_pkg::*; #(
  parameter logic [6:0]  DEV_ADDR    = 7'h48,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] HYST_RST    = 16'h4B00,
  parameter logic [15:0] OVER_RST    = 16'h5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_drive_low,
  input  logic [15:0] temp_in,
  output logic [7:0]  cfg_q,
  output logic [15:0] thyst_q,
  output logic [15:0] tover_q
);
  logic [1:0] rst_sync_q;
  logic       rst_i;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;

  tw_sync_edge #(.STAGES(SYNC_STAGES)) i_scl_sync (
    .clk(clk), .rst_n(rst_i), .d(scl_in),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));
  tw_sync_edge #(.STAGES(SYNC_STAGES)) i_sda_sync (
    .clk(clk), .rst_n(rst_i), .d(sda_in),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  reg_sel_e    ptr_q;
  logic        ptr_we, cfg_we, thr_we;
  logic [1:0]  ptr_d;
  logic [7:0]  cfg_d;
  logic [15:0] thr_d, rd_data;

  tw_bus_fsm #(.DEV_ADDR(DEV_ADDR)) i_fsm (
    .clk(clk), .rst_n(rst_i),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .ptr_q(ptr_q), .rd_data(rd_data),
    .ptr_we(ptr_we), .ptr_d(ptr_d), .cfg_we(cfg_we), .cfg_d(cfg_d),
    .thr_we(thr_we), .thr_d(thr_d), .sda_pull(sda_drive_low));

  tw_regs #(.DW(16), .HYST_RST(HYST_RST), .OVER_RST(OVER_RST)) i_regs (
    .clk(clk), .rst_n(rst_i),
    .ptr_we(ptr_we), .ptr_d(ptr_d), .cfg_we(cfg_we), .cfg_d(cfg_d),
    .thr_we(thr_we), .thr_d(thr_d), .temp_in(temp_in),
    .ptr_q(ptr_q), .cfg_q(cfg_q), .thyst_q(thyst_q), .tover_q(tover_q),
    .rd_data(rd_data));
endmodule

// File: tb/test_tw_ptr_target.sv
module test_tw_ptr_target;
  localparam logic [6:0] ADDR = 7'h48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_drive_low;
  logic [15:0] temp_in = 16'h1A80;
  logic [7:0]  cfg_q;
  logic [15:0] thyst_q, tover_q;
  wire         sda_bus = sda_m & ~sda_drive_low;
  int          checks = 0, errors = 0, r9_viol = 0;

  always #10 clk = ~clk;

  tw_ptr_target i_tw_ptr_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_drive_low(sda_drive_low), .temp_in(temp_in),
    .cfg_q(cfg_q), .thyst_q(thyst_q), .tover_q(tover_q));

  // R9 monitor: target output must never move while SCL is high
  always @(sda_drive_low) if (rst_n && scl_m) r9_viol++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic qw(input int n = 1); repeat (10 * n) @(negedge clk); endtask
  task automatic start_c;  sda_m = 1; scl_m = 1; qw; sda_m = 0; qw; scl_m = 0; qw; endtask
  task automatic rstart_c; sda_m = 1; qw; scl_m = 1; qw; sda_m = 0; qw; scl_m = 0; qw; endtask
  task automatic stop_c;   sda_m = 0; qw; scl_m = 1; qw; sda_m = 1; qw(2); endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw; scl_m = 1; qw(2); scl_m = 0; qw;
    end
    sda_m = 1; qw; scl_m = 1; qw; ack = ~sda_bus; qw; scl_m = 0; qw;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      qw; scl_m = 1; qw; b[i] = sda_bus; qw; scl_m = 0;
    end
    qw; sda_m = ~give_ack; qw; scl_m = 1; qw(2); scl_m = 0; qw; sda_m = 1;
  endtask

  // full write: returns 1 only if every byte was acknowledged
  task automatic wr_reg(input logic [1:0] ptr, input logic [15:0] d, output logic ok);
    logic a0, a1, a2, a3;
    a3 = 1;
    start_c; put_byte({ADDR, 1'b0}, a0); put_byte({6'd0, ptr}, a1);
    put_byte(d[15:8], a2);
    if (ptr != 2'b01) put_byte(d[7:0], a3);
    stop_c;
    ok = a0 & a1 & a2 & a3;
  endtask

  task automatic rd_reg(input logic set_ptr, input logic [1:0] ptr, input logic two,
                        output logic [15:0] v);
    logic a;
    v = '0;
    start_c;
    if (set_ptr) begin
      put_byte({ADDR, 1'b0}, a); put_byte({6'd0, ptr}, a); rstart_c;
    end
    put_byte({ADDR, 1'b1}, a);
    get_byte(two, v[15:8]);
    if (two) get_byte(1'b0, v[7:0]);
    stop_c;
  endtask

  // op[35:34] 0=write 1=read two bytes 2=read one byte; ptr[33:32]; data[31:16]; expected[15:0]
  localparam int NV = 9;
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 2'd1, 16'h6000, 16'h0001},
    {2'd2, 2'd1, 16'h0000, 16'h6000},
    {2'd0, 2'd2, 16'h3C80, 16'h0001},
    {2'd1, 2'd2, 16'h0000, 16'h3C80},
    {2'd0, 2'd3, 16'h4F00, 16'h0001},
    {2'd1, 2'd3, 16'h0000, 16'h4F00},
    {2'd1, 2'd0, 16'h0000, 16'h1A80},
    {2'd0, 2'd1, 16'h1F00, 16'h0001},
    {2'd2, 2'd1, 16'h0000, 16'h1F00}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ok, a0, a1, a2, a3;
    logic [7:0]  b;
    logic [15:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10 cfg reset", cfg_q, 8'h00);
    chk("R10 hyst reset", thyst_q, 16'h4B00);
    chk("R10 over reset", tover_q, 16'h5000);
    chk("R10 sda released", sda_drive_low, 1'b0);
    // R10/R3: pointer resets to temperature, read without a pointer byte
    rd_reg(1'b0, 2'd0, 1'b1, v);
    chk("R10 R3 reset pointer read", v, 16'h1A80);

    // table walk: R3 R4 R5 R7 R8
    for (int k = 0; k < NV; k++) begin
      logic [35:0] e;
      e = VEC[k];
      if (e[35:34] == 2'd0) begin
        wr_reg(e[33:32], e[31:16], ok);
        chk(e[33:32] == 2'd1 ? "R4 write acks" : "R5 write acks", ok, e[0]);
      end else begin
        rd_reg(1'b1, e[33:32], e[35:34] == 2'd1, v);
        if (e[35:34] == 2'd2) chk("R3 R7 one-byte read", v, e[15:0]);
        else                  chk("R3 R8 two-byte read", v, e[15:0]);
      end
    end
    chk("R4 cfg port", cfg_q, 8'h1F);
    chk("R5 hyst port", thyst_q, 16'h3C80);

    // R3: pointer persists (last set to settings byte)
    rd_reg(1'b0, 2'd0, 1'b0, v);
    chk("R3 pointer kept", v[15:8], 8'h1F);

    // R2: address mismatch is ignored
    start_c; put_byte({7'h49, 1'b0}, a0);
    chk("R2 mismatch no ack", a0, 1'b0);
    get_byte(1'b0, b);
    chk("R2 mismatch bus released", b, 8'hFF);
    stop_c;
    chk("R2 mismatch no write", cfg_q, 8'h1F);

    // R4: extra byte to settings register is NACKed and ignored
    start_c; put_byte({ADDR, 1'b0}, a0); put_byte(8'h01, a1);
    put_byte(8'hAA, a2); put_byte(8'h55, a3); stop_c;
    chk("R4 first byte ack", a2, 1'b1);
    chk("R4 extra byte nack", a3, 1'b0);
    chk("R4 cfg holds first byte", cfg_q, 8'hAA);

    // R5: stop after high byte leaves threshold unchanged
    start_c; put_byte({ADDR, 1'b0}, a0); put_byte(8'h02, a1); put_byte(8'h12, a2); stop_c;
    chk("R5 partial write no change", thyst_q, 16'h3C80);

    // R5: third byte NACKed
    start_c; put_byte({ADDR, 1'b0}, a0); put_byte(8'h03, a1);
    put_byte(8'h11, a2); put_byte(8'h22, a3); put_byte(8'h33, a0); stop_c;
    chk("R5 third byte nack", a0, 1'b0);
    chk("R5 over committed", tover_q, 16'h1122);

    // R6: temperature write acked and discarded
    wr_reg(2'd0, 16'hDEAD, ok);
    chk("R6 temp write acked", ok, 1'b1);
    rd_reg(1'b0, 2'd0, 1'b1, v);
    chk("R6 temp unchanged", v, 16'h1A80);

    // R8: NACK on high byte ends transmission
    start_c; put_byte({ADDR, 1'b1}, a0);
    get_byte(1'b0, b);
    chk("R8 msb only", b, 8'h1A);
    get_byte(1'b0, b);
    chk("R8 silent after nack", b, 8'hFF);
    stop_c;

    // R8: both bytes from one snapshot
    start_c; put_byte({ADDR, 1'b1}, a0);
    get_byte(1'b1, b);
    temp_in = 16'h2B40;
    get_byte(1'b0, b);
    stop_c;
    chk("R8 snapshot lsb", b, 8'h80);

    // R1: repeated START mid-write restarts address phase
    start_c; put_byte({ADDR, 1'b0}, a0); put_byte(8'h02, a1); put_byte(8'h77, a2);
    rstart_c; put_byte({ADDR, 1'b1}, a3);
    get_byte(1'b1, b); get_byte(1'b0, b); stop_c;
    chk("R1 restart acked", a3, 1'b1);
    chk("R1 restart no commit", thyst_q, 16'h3C80);

    chk("R9 sda changed only with scl low", r9_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule